// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a free-running 64-bit time of day counted in nanoseconds. Each clock cycle is one tick; on every tick the counter adds a programmable increment held as unsigned fixed point with 32 fractional bits. The fraction collects in an internal accumulator, and when that accumulator overflows the count gains one extra nanosecond. A 1.6 ns tick is therefore exact on average, with no separate cycle counter behind the time value.

Software reaches the block through a small 32-bit register port. The 64-bit time and the increment are each split into two words. A write to a low word only stages it, and the value commits when the matching high word is written. A read of the low time word freezes the upper half, so the next high-word read returns the upper half of the same instant. A link-speed input scales the programmed increment so the count stays in nanoseconds when the tick rate follows the link speed. One speed code marks a speed at which timing is unsupported, and at that code the counter halts.

Top module: `tod_counter`

## Requirements
- R1: After reset the time and fraction are zero, counting is disabled (control bit 0 reads 0), the increment reads 0x99999999 at address 3 and 0x01 at address 4, and rdata is zero.
- R2: With control bit 0 set and speed code 0, the {time, fraction} pair grows by the programmed increment on every cycle. A carry out of the 32-bit fraction adds one nanosecond.
- R3: Speed code 1 scales the increment by 2 and speed code 2 scales it by 20 before it is added. Speed code 0 uses a scale of 1.
- R4: Speed code 3, or control bit 0 cleared, holds the time unchanged.
- R5: A read at address 1 returns the live low time word one cycle later and captures the live upper word. A later read at address 2 returns that captured word, even if the live upper word has changed since.
- R6: A write at address 1 alone leaves the time unchanged. A write at address 2 loads {written word, last word written at address 1} and clears the fraction.
- R7: The tick in the cycle of an address-2 write is dropped, so a low-word read in the next cycle returns the written value exactly.
- R8: A write at address 3 alone leaves the active increment unchanged. A write at address 4 sets the increment to {wdata[7:0] as integer nanoseconds, last address-3 word as fraction}.
- R9: Address map: 0 control (bit 0 enables counting), 1 time low, 2 time high, 3 increment fraction, 4 increment integer. Reads of any other address return 0, and writes to them change nothing. rdata changes only when a read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed | input | 2 | Link speed code: 0 top or no link, 1 medium, 2 low, 3 unsupported |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after rd_en |

## Verification
Several properties are checked by assertions on every cycle: the time holds when counting is off or halted, it never moves backwards while counting, the increment changes only on a high-half write, a load clears the fraction, and a high-word read returns the captured snapshot. Other behaviour can only be shown by the bench's scenarios. These are the exact step sizes at each speed code, the fractional carry pattern of the 1.6 ns base step, the snapshot surviving a carry into the upper word, and staged low words having no effect on their own. The bench also covers the exact value seen on the cycle after a load.

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int DW        = 32,
  parameter int AW        = 3,
  parameter int INC_INT_W = 8,
  parameter logic [DW+INC_INT_W-1:0] BASE_INC = 40'h01_9999_9999,
  parameter int MULT_MID  = 2,
  parameter int MULT_LOW  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    speed,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int FRAC_W = DW;
  localparam int TIME_W = 2 * DW;
  localparam int INC_W  = FRAC_W + INC_INT_W;
  localparam int MUL_W  = $clog2(MULT_LOW + 1);
  localparam int STEP_W = INC_W + MUL_W;

  localparam logic [AW-1:0] A_CTL  = AW'(0);
  localparam logic [AW-1:0] A_TLO  = AW'(1);
  localparam logic [AW-1:0] A_THI  = AW'(2);
  localparam logic [AW-1:0] A_ILO  = AW'(3);
  localparam logic [AW-1:0] A_IHI  = AW'(4);

  logic [TIME_W-1:0] tod;
  logic [FRAC_W-1:0] frac;
  logic [INC_W-1:0]  inc;
  logic [DW-1:0]     tlo_stage, ilo_stage, snap_hi;
  logic              en;
  logic [MUL_W-1:0]  mult;
  logic [DW-1:0]     rd_val;

  wire wr_ctl   = wr_en && addr == A_CTL;
  wire wr_tlo   = wr_en && addr == A_TLO;
  wire load     = wr_en && addr == A_THI;
  wire wr_ilo   = wr_en && addr == A_ILO;
  wire wr_ihi   = wr_en && addr == A_IHI;
  wire count_on = en && speed != 2'd3;

  always_comb begin
    case (speed)
      2'd1:    mult = MUL_W'(MULT_MID);
      2'd2:    mult = MUL_W'(MULT_LOW);
      default: mult = MUL_W'(1);
    endcase
  end

  wire [STEP_W-1:0] step     = STEP_W'(inc) * STEP_W'(mult);
  wire [FRAC_W:0]   frac_sum = {1'b0, frac} + {1'b0, step[FRAC_W-1:0]};
  wire [TIME_W-1:0] tod_next = tod + TIME_W'(step[STEP_W-1:FRAC_W])
                                   + TIME_W'(frac_sum[FRAC_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tod  <= '0;
      frac <= '0;
    end else if (load) begin
      tod  <= {wdata, tlo_stage};
      frac <= '0;
    end else if (count_on) begin
      tod  <= tod_next;
      frac <= frac_sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      inc       <= BASE_INC;
      tlo_stage <= '0;
      ilo_stage <= '0;
    end else begin
      if (wr_ctl) en        <= wdata[0];
      if (wr_tlo) tlo_stage <= wdata;
      if (wr_ilo) ilo_stage <= wdata;
      if (wr_ihi) inc       <= {wdata[INC_INT_W-1:0], ilo_stage};
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rd_val = DW'(en);
      A_TLO:   rd_val = tod[DW-1:0];
      A_THI:   rd_val = snap_hi;
      A_ILO:   rd_val = inc[FRAC_W-1:0];
      A_IHI:   rd_val = DW'(inc[INC_W-1:FRAC_W]);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      snap_hi <= '0;
    end else if (rd_en) begin
      rdata <= rd_val;
      if (addr == A_TLO) snap_hi <= tod[TIME_W-1:DW];
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_on && !load) |=> $stable(tod));

  assert_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count_on && !load) |=> tod >= $past(tod));

  assert_inc_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ihi |=> $stable(inc));

  assert_load_frac_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> frac == '0);

  assert_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_THI) |=> rdata == $past(snap_hi));

  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tod_counter_test.sv
module tod_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  speed = 2'd0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;

  int compared = 0, mismatched = 0;
  string phase = "R1";
  bit done = 0;

  tod_counter uut (.clk(clk), .rst_n(rst_n), .speed(speed), .wr_en(wr_en),
                   .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata));

  always #2 clk = ~clk;

  // behavioural reference
  longint unsigned m_time;
  bit [31:0] m_frac, m_tlo, m_ilo, m_snap, m_rdata;
  bit [39:0] m_inc;
  bit        m_en;

  always @(posedge clk) begin
    bit [95:0] acc;
    int k;
    if (!rst_n) begin
      m_time = 0; m_frac = 0; m_tlo = 0; m_ilo = 0; m_snap = 0;
      m_rdata = 0; m_inc = 40'h01_9999_9999; m_en = 0;
    end else begin
      if (rd_en) begin
        case (addr)
          3'd0: m_rdata = {31'd0, m_en};
          3'd1: begin m_rdata = m_time[31:0]; m_snap = m_time[63:32]; end
          3'd2: m_rdata = m_snap;
          3'd3: m_rdata = m_inc[31:0];
          3'd4: m_rdata = {24'd0, m_inc[39:32]};
          default: m_rdata = 0;
        endcase
      end
      if (wr_en && addr == 3'd2) begin
        m_time = {wdata, m_tlo}; m_frac = 0;
      end else if (m_en && speed != 2'd3) begin
        k = (speed == 2'd1) ? 2 : (speed == 2'd2) ? 20 : 1;
        acc = {m_time, m_frac} + 96'(m_inc) * 96'(k);
        m_time = acc[95:32]; m_frac = acc[31:0];
      end
      if (wr_en) begin
        case (addr)
          3'd0: m_en = wdata[0];
          3'd1: m_tlo = wdata;
          3'd3: m_ilo = wdata;
          3'd4: m_inc = {wdata[7:0], m_ilo};
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) if (!done) begin
    compared++;
    if (rdata !== m_rdata) begin
      mismatched++;
      $display("FAIL %s cycle compare: rdata=%h expected=%h", phase, rdata, m_rdata);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    rd_en = 1; addr = a;
    @(posedge clk); #1;
    rd_en = 0; addr = 0;
    v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [31:0] a, b, c;
    idle(3);
    rst_n = 1;
    idle(1);
    phase = "R1";
    chk("R1 rdata after reset", rdata, 32'd0);
    rd(3'd3, a); chk("R1 inc fraction", a, 32'h9999_9999);
    rd(3'd4, a); chk("R1 inc integer", a, 32'h01);
    rd(3'd0, a); chk("R1 control", a, 32'd0);
    rd(3'd1, a); chk("R1 time low", a, 32'd0);

    phase = "R2";
    wr(3'd0, 32'd1);
    idle(10);
    for (int i = 0; i < 8; i++) begin
      rd(3'd1, a); rd(3'd1, b);
      compared++;
      if (!((b - a) == 1 || (b - a) == 2)) begin
        mismatched++;
        $display("FAIL R2 base step: actual=%0d expected=1 or 2", b - a);
      end
    end

    phase = "R8";
    wr(3'd3, 32'd0);
    rd(3'd3, a); chk("R8 fraction staged only", a, 32'h9999_9999);
    wr(3'd4, 32'd5);
    rd(3'd3, a); chk("R8 fraction committed", a, 32'd0);
    rd(3'd4, a); chk("R8 integer committed", a, 32'd5);
    rd(3'd1, a); rd(3'd1, b); chk("R8 step 5", b - a, 32'd5);

    phase = "R3";
    speed = 2'd1; idle(2);
    rd(3'd1, a); rd(3'd1, b); chk("R3 medium step", b - a, 32'd10);
    speed = 2'd2; idle(2);
    rd(3'd1, a); rd(3'd1, b); chk("R3 low step", b - a, 32'd100);

    phase = "R4";
    speed = 2'd3; idle(2);
    rd(3'd1, a); idle(5); rd(3'd1, b); chk("R4 halted speed", b, a);
    speed = 2'd0; wr(3'd0, 32'd0);
    rd(3'd1, a); idle(5); rd(3'd1, b); chk("R4 disabled", b, a);

    phase = "R6";
    wr(3'd1, 32'hDEAD_BEEF);
    rd(3'd1, b); chk("R6 low write alone", b, a);
    wr(3'd2, 32'h0000_0007);
    rd(3'd1, a); chk("R6 load low", a, 32'hDEAD_BEEF);
    rd(3'd2, a); chk("R6 load high", a, 32'h7);

    phase = "R7";
    wr(3'd0, 32'd1);
    speed = 2'd2;
    wr(3'd1, 32'hFFFF_FF00);
    wr(3'd2, 32'd0);
    rd(3'd1, a); chk("R7 exact after load", a, 32'hFFFF_FF00);

    phase = "R5";
    idle(20);
    rd(3'd2, a); chk("R5 snapshot high kept", a, 32'd0);
    rd(3'd1, a); rd(3'd2, b); chk("R5 new snapshot high", b, 32'd1);

    phase = "R9";
    speed = 2'd3;
    rd(3'd6, a); chk("R9 unmapped read", a, 32'd0);
    wr(3'd5, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd0, a); chk("R9 control intact", a, 32'd1);
    rd(3'd4, a); chk("R9 increment intact", a, 32'd5);
    c = rdata; idle(4); chk("R9 rdata holds", rdata, c);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule